// File: doc/BRIEF.md
# Indicator Output Source Selector

This block drives a bank of indicator outputs: four LEDs beside the two radio chains, four red and four green user LEDs, and two seven-segment digits, each with a decimal point. Every output bit picks its own value. It can take a bit that software wrote into a register. Under hardware control it can instead take an external port bit or a shared PWM level that arrives on one input. Each digit can also turn a 4-bit hex value into its segment pattern.

Software reaches the block through a plain 32-bit word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the address. The same port reports the push buttons and DIP switch after a two-flop synchronizer. The PWM generator, debouncing and any bus protocol adaptation sit outside the block.

Top module: `led_src_sel`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0F000000 and every other writable register reads 0. The RF LEDs follow `hw_rf_i` and all other outputs show 0.
- R2: Each control-word bit selects the source of one output: 0 selects the software register and 1 selects hardware. Bits [7:0] select for the left digit and [15:8] for the right digit, where field bit k (k=0..6) is segment a..g and field bit 7 is the decimal point. Bits [19:16] select for the red LEDs, [23:20] for the green LEDs and [27:24] for the RF LEDs.
- R3: The hardware-mode word (address 1) uses the same layout. For a bit under hardware control, 0 takes the matching port bit and 1 takes `pwm_i`. The hardware-mode word has no effect on bits under software control.
- R4: Control-word bits 29 (left) and 28 (right) turn on hex decode. When decode is on, digit-register bits [3:0] give active-high segments {g..a}: 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 B:7C C:39 D:5E E:79 F:71.
- R5: With decode off, digit-register bits [6:0] drive segments a..g directly, with bit 0 driving segment a. With decode on, bits [6:4] have no effect.
- R6: Digit-register bit 8 drives the decimal point, which is output bit 7, in both decode modes.
- R7: The red (address 4), green (address 5) and RF (address 6) registers use bits [3:0], and bit n drives output bit n. On the RF LEDs, bit 0 is chain-A green, bit 1 is chain-A red, bit 2 is chain-B green and bit 3 is chain-B red. The left and right digit registers are at addresses 2 and 3.
- R8: The read-only input word (address 7) holds the up, middle and down buttons (`btn_i[2:0]`) on bits 6, 5 and 4, and the DIP switch on bits [3:0]. An input change is readable after the second rising edge and not after the first.
- R9: Reading an output register returns the value software wrote, even when that output is under hardware control.
- R10: Reserved bits read as 0 and writes to them are dropped. The writable masks are: control 0x3FFFFFFF, hardware-mode 0x0FFFFFFF, digits 0x17F and LEDs 0xF. Writes to address 7 are ignored, and addresses 8 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_i | input | 1 | Shared PWM level |
| hw_rf_i | input | 4 | Hardware port bits for RF LEDs |
| hw_red_i | input | 4 | Hardware port bits for red LEDs |
| hw_green_i | input | 4 | Hardware port bits for green LEDs |
| hw_seg_l_i | input | 8 | Hardware port bits for left digit {dp,g..a} |
| hw_seg_r_i | input | 8 | Hardware port bits for right digit {dp,g..a} |
| btn_i | input | 3 | Buttons {up,mid,down} |
| dip_i | input | 4 | DIP switch |
| rf_led_o | output | 4 | RF LEDs |
| red_led_o | output | 4 | Red user LEDs |
| green_led_o | output | 4 | Green user LEDs |
| seg_l_o | output | 8 | Left digit {dp,g..a}, active high |
| seg_r_o | output | 8 | Right digit {dp,g..a}, active high |

## Verification
Two events can meet in one cycle: a register write that moves an output onto or off hardware control, and a change on the hardware source the output would then follow. The bench drives both in one cycle. It writes the control word while it flips `pwm_i`, then it writes a software LED value while that LED follows PWM. The output is judged after the edge. It must show the PWM level from the cycle the write lands, and the readback must show the value software wrote rather than the driven value.

// File: rtl/led_src_pkg.sv
package led_src_pkg;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int NREG   = 7;
  localparam int NSEG   = 7;
  localparam int DIGW   = NSEG + 1;
  localparam int NLED   = 4;
  localparam int NBTN   = 3;
  localparam int NDIP   = 4;
  localparam int INW    = NBTN + NDIP;
  localparam int SYNC_N = 2;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_HWSEL = 4'd1;
  localparam logic [AW-1:0] A_DIG_L = 4'd2;
  localparam logic [AW-1:0] A_DIG_R = 4'd3;
  localparam logic [AW-1:0] A_RED   = 4'd4;
  localparam logic [AW-1:0] A_GRN   = 4'd5;
  localparam logic [AW-1:0] A_RF    = 4'd6;
  localparam logic [AW-1:0] A_IN    = 4'd7;

  localparam int SEL_L   = 0;
  localparam int SEL_R   = 8;
  localparam int SEL_RED = 16;
  localparam int SEL_GRN = 20;
  localparam int SEL_RF  = 24;
  localparam int DEC_R   = 28;
  localparam int DEC_L   = 29;
  localparam int DP_BIT  = 8;

  function automatic logic [DW-1:0] reg_mask(input int idx);
    case (idx)
      0:       return 32'h3FFF_FFFF;
      1:       return 32'h0FFF_FFFF;
      2, 3:    return 32'h0000_017F;
      default: return 32'h0000_000F;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_rst(input int idx);
    return (idx == 0) ? 32'h0F00_0000 : '0;
  endfunction

  // active-high segments, bit 0 = a
  function automatic logic [NSEG-1:0] hex_to_seg(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F;  4'h1: return 7'h06;
      4'h2: return 7'h5B;  4'h3: return 7'h4F;
      4'h4: return 7'h66;  4'h5: return 7'h6D;
      4'h6: return 7'h7D;  4'h7: return 7'h07;
      4'h8: return 7'h7F;  4'h9: return 7'h6F;
      4'hA: return 7'h77;  4'hB: return 7'h7C;
      4'hC: return 7'h39;  4'hD: return 7'h5E;
      4'hE: return 7'h79;  default: return 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/led_src_sync.sv
module led_src_sync #(
  parameter int W = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/led_src_regs.sv
module led_src_regs
  import led_src_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [INW-1:0] in_word_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] hwsel_o,
  output logic [DW-1:0] dig_l_o,
  output logic [DW-1:0] dig_r_o,
  output logic [DW-1:0] red_o,
  output logic [DW-1:0] grn_o,
  output logic [DW-1:0] rf_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_mask(i);
    localparam logic [DW-1:0] RSTV = reg_rst(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[i] <= RSTV;
      else if (we_i && addr_i == AW'(i))            regs_q[i] <= wdata_i & MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (addr_i == AW'(i)) rdata_o = regs_q[i];
    if (addr_i == A_IN) rdata_o = {{(DW-INW){1'b0}}, in_word_i};
  end

  assign ctrl_o  = regs_q[A_CTRL];
  assign hwsel_o = regs_q[A_HWSEL];
  assign dig_l_o = regs_q[A_DIG_L];
  assign dig_r_o = regs_q[A_DIG_R];
  assign red_o   = regs_q[A_RED];
  assign grn_o   = regs_q[A_GRN];
  assign rf_o    = regs_q[A_RF];
endmodule

// File: rtl/led_src_digit.sv
module led_src_digit
  import led_src_pkg::*;
(
  input  logic [DP_BIT:0]  dig_i,
  input  logic             dec_en_i,
  output logic [DIGW-1:0]  seg_o
);
  logic [NSEG-1:0] body;
  assign body  = dec_en_i ? hex_to_seg(dig_i[3:0]) : dig_i[NSEG-1:0];
  assign seg_o = {dig_i[DP_BIT], body};  // dp bypasses decode
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux #(
  parameter int W = 4
) (
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] port_i,
  input  logic         pwm_i,
  input  logic [W-1:0] hw_en_i,
  input  logic [W-1:0] pwm_sel_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = hw_en_i[i] ? (pwm_sel_i[i] ? pwm_i : port_i[i]) : sw_i[i];
  end
endmodule

// File: rtl/led_src_sel.sv
module led_src_sel
  import led_src_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             pwm_i,
  input  logic [NLED-1:0]  hw_rf_i,
  input  logic [NLED-1:0]  hw_red_i,
  input  logic [NLED-1:0]  hw_green_i,
  input  logic [DIGW-1:0]  hw_seg_l_i,
  input  logic [DIGW-1:0]  hw_seg_r_i,
  input  logic [NBTN-1:0]  btn_i,
  input  logic [NDIP-1:0]  dip_i,
  output logic [NLED-1:0]  rf_led_o,
  output logic [NLED-1:0]  red_led_o,
  output logic [NLED-1:0]  green_led_o,
  output logic [DIGW-1:0]  seg_l_o,
  output logic [DIGW-1:0]  seg_r_o
);
  logic [INW-1:0]  in_sync;
  logic [DW-1:0]   ctrl_w, hwsel_w, dig_l_w, dig_r_w, red_w, grn_w, rf_w;
  logic [DIGW-1:0] sw_seg_l, sw_seg_r;

  led_src_sync #(.W(INW), .STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i({btn_i, dip_i}), .q_o(in_sync)
  );

  led_src_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .in_word_i(in_sync), .rdata_o,
    .ctrl_o(ctrl_w), .hwsel_o(hwsel_w), .dig_l_o(dig_l_w), .dig_r_o(dig_r_w),
    .red_o(red_w), .grn_o(grn_w), .rf_o(rf_w)
  );

  led_src_digit u_dig_l (.dig_i(dig_l_w[DP_BIT:0]), .dec_en_i(ctrl_w[DEC_L]), .seg_o(sw_seg_l));
  led_src_digit u_dig_r (.dig_i(dig_r_w[DP_BIT:0]), .dec_en_i(ctrl_w[DEC_R]), .seg_o(sw_seg_r));

  led_src_mux #(.W(NLED)) u_mux_rf (
    .sw_i(rf_w[NLED-1:0]), .port_i(hw_rf_i), .pwm_i,
    .hw_en_i(ctrl_w[SEL_RF +: NLED]), .pwm_sel_i(hwsel_w[SEL_RF +: NLED]), .out_o(rf_led_o)
  );
  led_src_mux #(.W(NLED)) u_mux_red (
    .sw_i(red_w[NLED-1:0]), .port_i(hw_red_i), .pwm_i,
    .hw_en_i(ctrl_w[SEL_RED +: NLED]), .pwm_sel_i(hwsel_w[SEL_RED +: NLED]), .out_o(red_led_o)
  );
  led_src_mux #(.W(NLED)) u_mux_grn (
    .sw_i(grn_w[NLED-1:0]), .port_i(hw_green_i), .pwm_i,
    .hw_en_i(ctrl_w[SEL_GRN +: NLED]), .pwm_sel_i(hwsel_w[SEL_GRN +: NLED]), .out_o(green_led_o)
  );
  led_src_mux #(.W(DIGW)) u_mux_l (
    .sw_i(sw_seg_l), .port_i(hw_seg_l_i), .pwm_i,
    .hw_en_i(ctrl_w[SEL_L +: DIGW]), .pwm_sel_i(hwsel_w[SEL_L +: DIGW]), .out_o(seg_l_o)
  );
  led_src_mux #(.W(DIGW)) u_mux_r (
    .sw_i(sw_seg_r), .port_i(hw_seg_r_i), .pwm_i,
    .hw_en_i(ctrl_w[SEL_R +: DIGW]), .pwm_sel_i(hwsel_w[SEL_R +: DIGW]), .out_o(seg_r_o)
  );
endmodule

// File: rtl/led_src_sel_chk.sv
module led_src_sel_chk
  import led_src_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic            pwm_i,
  input logic [NBTN-1:0] btn_i,
  input logic [NDIP-1:0] dip_i,
  input logic [DW-1:0]   ctrl_i,
  input logic [DW-1:0]   hwsel_i,
  input logic [DW-1:0]   dig_l_i,
  input logic [NLED-1:0] red_led_o,
  input logic [DIGW-1:0] seg_l_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R8: input word shows pins from two edges earlier
  a_r8_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && addr_i == A_IN) |-> rdata_o[INW-1:0] == $past({btn_i, dip_i}, 2));

  // R9: readback of a written LED register
  a_r9_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RED) |=> (addr_i != A_RED || rdata_o[NLED-1:0] == $past(wdata_i[NLED-1:0])));

  // R3: PWM selected path
  a_r3_pwm_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[SEL_RED] && hwsel_i[SEL_RED]) |-> red_led_o[0] == pwm_i);

  // R6: dp follows register bit under software control
  a_r6_dp_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[SEL_L + DIGW - 1] |-> seg_l_o[DIGW-1] == dig_l_i[DP_BIT]);

  // R10: reserved control bits read zero
  a_r10_ctrl_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTRL) |-> rdata_o[DW-1:DEC_L+1] == '0);
endmodule

bind led_src_sel led_src_sel_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .pwm_i(pwm_i), .btn_i(btn_i), .dip_i(dip_i),
  .ctrl_i(ctrl_w), .hwsel_i(hwsel_w), .dig_l_i(dig_l_w),
  .red_led_o(red_led_o), .seg_l_o(seg_l_o)
);

// File: tb/led_src_sel_tb_top.sv
module led_src_sel_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pwm = 1'b0;
  logic [3:0] hw_rf = '0, hw_red = '0, hw_grn = '0;
  logic [7:0] hw_l = '0, hw_r = '0;
  logic [2:0] btn = '0;
  logic [3:0] dip = '0;
  logic [3:0] rf_o, red_o, grn_o;
  logic [7:0] seg_l, seg_r;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  led_src_sel dut_i (
    .clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pwm_i(pwm), .hw_rf_i(hw_rf), .hw_red_i(hw_red), .hw_green_i(hw_grn),
    .hw_seg_l_i(hw_l), .hw_seg_r_i(hw_r), .btn_i(btn), .dip_i(dip),
    .rf_led_o(rf_o), .red_led_o(red_o), .green_led_o(grn_o), .seg_l_o(seg_l), .seg_r_o(seg_r)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; 10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v); chk("R1 ctrl reset", v, 32'h0F00_0000);
    rd(4'd1, v); chk("R1 hwsel reset", v, 0);
    rd(4'd4, v); chk("R1 red reg reset", v, 0);
    hw_rf = 4'hA; #1;
    chk("R1 rf follows port", rf_o, 4'hA);
    chk("R1 red out", red_o, 0);
    chk("R1 seg_l out", seg_l, 0);
  endtask

  task automatic t_sw_leds();
    wr(4'd0, 0);
    wr(4'd4, 32'h5); chk("R7 red sw", red_o, 4'h5);
    wr(4'd5, 32'hA); chk("R7 green sw", grn_o, 4'hA);
    wr(4'd6, 32'h1); chk("R7 rf bit0 chainA green", rf_o, 4'h1);
    wr(4'd6, 32'h8); chk("R7 rf bit3 chainB red", rf_o, 4'h8);
  endtask

  task automatic t_hw_port();
    hw_grn = 4'h5;
    wr(4'd0, 32'h0030_0000);
    chk("R2 per-bit mix green", grn_o, 4'h9);
    chk("R2 red stays sw", red_o, 4'h5);
    hw_l = 8'hC3;
    wr(4'd0, 32'h0000_00FF); chk("R2 left digit hw", seg_l, 8'hC3);
    hw_r = 8'h81;
    wr(4'd0, 32'h0000_FF00); chk("R2 right digit hw", seg_r, 8'h81);
  endtask

  task automatic t_pwm();
    hw_red = 4'h0; pwm = 1'b1;
    wr(4'd1, 32'h0003_0000);
    wr(4'd0, 32'h000F_0000); chk("R3 pwm high", red_o, 4'h3);
    pwm = 1'b0; #1 chk("R3 pwm low", red_o, 4'h0);
    hw_red = 4'hC; pwm = 1'b1; #1 chk("R3 mix pwm port", red_o, 4'hF);
    wr(4'd0, 0); chk("R3 hwsel no effect under sw", red_o, 4'h5);
    wr(4'd1, 0);
  endtask

  task automatic t_hex();
    wr(4'd0, 32'h3000_0000);
    for (int v = 0; v < 16; v++) begin
      wr(4'd2, 32'h70 | v);
      chk($sformatf("R4 R5 left hex %0d", v), seg_l, {1'b0, exp_seg(4'(v))});
      wr(4'd3, v);
      chk($sformatf("R4 right hex %0d", v), seg_r, {1'b0, exp_seg(4'(v))});
    end
  endtask

  task automatic t_raw_dp();
    wr(4'd2, 32'h103); chk("R6 dp in decode", seg_l, 8'hCF);
    wr(4'd0, 0);
    wr(4'd2, 32'h55); chk("R5 raw segments", seg_l, 8'h55);
    wr(4'd2, 32'h100); chk("R6 dp in raw", seg_l, 8'h80);
  endtask

  task automatic t_inputs();
    logic [31:0] v;
    @(negedge clk); btn = 3'b101; dip = 4'h6; addr = 4'd7;
    @(negedge clk); #1 chk("R8 not after one edge", rdata, 0);
    @(negedge clk); #1 chk("R8 after two edges", rdata, 32'h56);
    btn = 3'b010; dip = 4'h9;
    repeat (3) @(negedge clk);
    rd(4'd7, v); chk("R8 mid + dip", v, 32'h29);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    hw_grn = 4'hC;
    wr(4'd0, 32'h00F0_0000);
    wr(4'd5, 32'h3);
    chk("R9 driven from port", grn_o, 4'hC);
    rd(4'd5, v); chk("R9 readback sw value", v, 32'h3);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R10 ctrl mask", v, 32'h3FFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); chk("R10 hwsel mask", v, 32'h0FFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R10 digit mask", v, 32'h17F);
    wr(4'd6, 32'hFFFF_FFF0); rd(4'd6, v); chk("R10 rf mask", v, 0);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, v); chk("R10 input ro", v, 32'h29);
    rd(4'd9, v); chk("R10 unmapped", v, 0);
    wr(4'd0, 0); wr(4'd1, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(4'd4, 32'h1);
    wr(4'd1, 32'h0001_0000);
    pwm = 1'b1;
    @(negedge clk); we = 1'b1; addr = 4'd0; wdata = 32'h0001_0000; pwm = 1'b0;
    #1 chk("R2 before edge sw", red_o, 4'h1);
    @(negedge clk); we = 1'b0;
    #1 chk("R3 same-cycle pwm", red_o, 4'h0);
    pwm = 1'b1;
    @(negedge clk); we = 1'b1; addr = 4'd4; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    #1 chk("R3 pwm over sw write", red_o, 4'h1);
    rd(4'd4, v); chk("R9 sw value under pwm", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_sw_leds();
    t_hw_port();
    t_pwm();
    t_hex();
    t_raw_dp();
    t_inputs();
    t_readback();
    t_reserved();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule